// File: doc/BRIEF.md
# Segment Limit and Access Checker

This block checks a single memory access against a segment descriptor that is already held in the pipeline. Each request carries a byte offset, the access length, the kind of access (read, write or instruction fetch) and the descriptor attributes that matter. These attributes are the 20-bit limit, the granularity flag, the expand-down flag, the code/data flag and the combined read/write permission flag. One clock edge later the block returns a fault flag and a two-bit cause code. It does not translate addresses, walk descriptor tables or raise the exception. The surrounding pipeline uses the result for those steps.

The bound check covers segments that grow up and segments that grow down. With granularity set, the limit counts 4 KiB pages. The rights check blocks writes that the segment type forbids. It also blocks reads from execute-only code and instruction fetches from data segments.

Top module: `seg_access_checker`

## Requirements
- R1: `rsp_valid` equals `req_valid` from the previous clock edge. A cycle without a request gives `rsp_valid`, `rsp_fault` and `rsp_cause` all 0 on the next edge. Synchronous reset clears all three.
- R2: `rsp_cause` encoding: 0 means no fault, 1 means a bound violation, 2 means a write not permitted and 3 means a read or fetch not permitted. `rsp_fault` is 1 exactly when `rsp_cause` is nonzero.
- R3: For a segment that grows up, an access passes the bound check only when its last byte is at or below the effective limit. The limit byte itself is allowed.
- R4: The effective limit is the 20-bit limit zero-extended to 32 bits when `seg_gran`=0. When `seg_gran`=1 it is the limit shifted left by 12 with the low 12 bits all ones.
- R5: For a data segment with `seg_expand_down`=1, an access passes the bound check only when two conditions hold. The offset must be at or above the effective limit, and the last byte must be at or below the top bound. The top bound is 0xFFFFF when `seg_gran`=0 and 0xFFFFFFFF when `seg_gran`=1.
- R6: The last byte is `req_offset + req_len_m1`, where `req_len_m1` is the byte count minus one. A sum that carries past bit 31 is a bound fault.
- R7: A write (`req_kind`=1) to a code segment (`seg_is_code`=1) gives cause 2.
- R8: A write to a data segment whose `seg_rw`=0 (read-only) gives cause 2. With `seg_rw`=1 the write is permitted.
- R9: A read from a code segment with `seg_rw`=0 (execute-only) gives cause 3. A fetch (`req_kind`=2) from any data segment gives cause 3. A fetch from a code segment is permitted whatever the value of `seg_rw`.
- R10: A rights fault (cause 2 or 3) takes precedence over a bound fault on the same access.
- R11: `seg_expand_down` has no effect on code segments. They are always checked as growing up.
- R12: `req_kind` encoding: 0 is read, 1 is write, 2 is fetch, and 3 is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_offset | input | ADDR_W | Byte offset within the segment |
| req_len_m1 | input | LEN_W | Access length in bytes minus one |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| seg_limit | input | LIMIT_W | Raw segment limit |
| seg_gran | input | 1 | 1 = limit counts 4 KiB pages |
| seg_expand_down | input | 1 | 1 = data segment grows down |
| seg_is_code | input | 1 | 1 = code segment, 0 = data segment |
| seg_rw | input | 1 | Code: readable; data: writable |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_fault | output | 1 | Access violates the descriptor |
| rsp_cause | output | 2 | Fault cause code |

## Verification
The bench uses the default parameters: a 32-bit offset, a 20-bit limit and a 3-bit length field, so accesses can be up to 8 bytes long. With these values the effective limit with granularity set reaches the top of the 32-bit space. Multi-byte accesses can then end exactly on 0xFFFFFFFF or carry past it, and grow-down segments can be probed at both bounds. Directed corner cases are followed by pseudo-random requests drawn around the limit. Some of these requests are back to back, which tests the one-cycle result timing under continuous traffic.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_READX = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_BOUND = 2'd1,
        CAUSE_WRITE = 2'd2,
        CAUSE_READ  = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic         fault;
        fault_cause_e cause;
    } chk_result_t;

    // Rights violations win over bound violations.
    function automatic fault_cause_e merge_cause(input fault_cause_e rights,
                                                 input logic bound_bad);
        if (rights != CAUSE_NONE) return rights;
        if (bound_bad)            return CAUSE_BOUND;
        return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/seg_bound_eval.sv
module seg_bound_eval #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20,
    parameter int LEN_W   = 3
) (
    input  logic [ADDR_W-1:0]  offset,
    input  logic [LEN_W-1:0]   len_m1,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               gran,
    input  logic               grows_down,
    output logic               bound_bad
);
    localparam int PAGE_BITS = ADDR_W - LIMIT_W;

    logic [ADDR_W:0]   last_sum;
    logic [ADDR_W-1:0] eff_limit;
    logic [ADDR_W-1:0] top_bound;
    logic              carry_out;
    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        last_sum  = {1'b0, offset} + {{(ADDR_W + 1 - LEN_W){1'b0}}, len_m1};
        carry_out = last_sum[ADDR_W];
        last_byte = last_sum[ADDR_W-1:0];
        eff_limit = gran ? {limit, {PAGE_BITS{1'b1}}}
                         : {{PAGE_BITS{1'b0}}, limit};
        top_bound = gran ? {ADDR_W{1'b1}}
                         : {{PAGE_BITS{1'b0}}, {LIMIT_W{1'b1}}};
        if (carry_out)
            bound_bad = 1'b1;
        else if (grows_down)
            bound_bad = (offset < eff_limit) || (last_byte > top_bound);
        else
            bound_bad = (last_byte > eff_limit);
    end
endmodule

// File: rtl/seg_rights_eval.sv
module seg_rights_eval
    import seg_chk_pkg::*;
(
    input  acc_kind_e    kind,
    input  logic         is_code,
    input  logic         rw,
    output fault_cause_e rights_cause
);
    always_comb begin
        rights_cause = CAUSE_NONE;
        unique case (kind)
            KIND_WRITE: if (is_code || !rw) rights_cause = CAUSE_WRITE;
            KIND_FETCH: if (!is_code)       rights_cause = CAUSE_READ;
            default:    if (is_code && !rw) rights_cause = CAUSE_READ;
        endcase
    end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20,
    parameter int LEN_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_offset,
    input  logic [LEN_W-1:0]   req_len_m1,
    input  logic [1:0]         req_kind,
    input  logic [LIMIT_W-1:0] seg_limit,
    input  logic               seg_gran,
    input  logic               seg_expand_down,
    input  logic               seg_is_code,
    input  logic               seg_rw,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_cause
);
    acc_kind_e    kind;
    fault_cause_e rights_cause;
    logic         bound_bad;
    logic         grows_down;
    chk_result_t  res_nxt;
    chk_result_t  res_q;
    logic         valid_q;

    assign kind       = acc_kind_e'(req_kind);
    assign grows_down = seg_expand_down && !seg_is_code;

    seg_bound_eval #(
        .ADDR_W (ADDR_W),
        .LIMIT_W(LIMIT_W),
        .LEN_W  (LEN_W)
    ) bound_i (
        .offset    (req_offset),
        .len_m1    (req_len_m1),
        .limit     (seg_limit),
        .gran      (seg_gran),
        .grows_down(grows_down),
        .bound_bad (bound_bad)
    );

    seg_rights_eval rights_i (
        .kind        (kind),
        .is_code     (seg_is_code),
        .rw          (seg_rw),
        .rights_cause(rights_cause)
    );

    always_comb begin
        res_nxt.cause = merge_cause(rights_cause, bound_bad);
        res_nxt.fault = bound_bad || (rights_cause != CAUSE_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '{fault: 1'b0, cause: CAUSE_NONE};
        end else begin
            valid_q <= req_valid;
            if (req_valid) res_q <= res_nxt;
            else           res_q <= '{fault: 1'b0, cause: CAUSE_NONE};
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_fault = res_q.fault;
    assign rsp_cause = res_q.cause;

    // R1: result timing follows the request by one edge
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_cause == 2'd0));
    // R2: fault flag agrees with cause code
    a_r2_flag_matches_cause: assert property (@(posedge clk) disable iff (rst)
        rsp_fault == (rsp_cause != 2'd0));
    // R7: code segments are never writable
    a_r7_code_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1 && seg_is_code) |=> rsp_cause == 2'd2);
    // R8: read-only data rejects writes
    a_r8_ro_data_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1 && !seg_is_code && !seg_rw) |=> rsp_cause == 2'd2);
    // R9: fetch from data is a read/execute rights fault
    a_r9_fetch_data: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && !seg_is_code) |=> rsp_cause == 2'd3);
    // R6: a last byte past the 32-bit range always faults
    a_r6_wrap_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_offset == {ADDR_W{1'b1}} && req_len_m1 != '0) |=> rsp_fault);
endmodule

// File: tb/seg_access_checker_tb_top.sv
module seg_access_checker_tb_top;
    localparam int ADDR_W  = 32;
    localparam int LIMIT_W = 20;
    localparam int LEN_W   = 3;

    logic               clk = 1'b0;
    logic               rst;
    logic               req_valid;
    logic [ADDR_W-1:0]  req_offset;
    logic [LEN_W-1:0]   req_len_m1;
    logic [1:0]         req_kind;
    logic [LIMIT_W-1:0] seg_limit;
    logic               seg_gran, seg_expand_down, seg_is_code, seg_rw;
    logic               rsp_valid, rsp_fault;
    logic [1:0]         rsp_cause;

    always #2.5 clk = ~clk;

    seg_access_checker #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_offset(req_offset),
        .req_len_m1(req_len_m1), .req_kind(req_kind), .seg_limit(seg_limit),
        .seg_gran(seg_gran), .seg_expand_down(seg_expand_down),
        .seg_is_code(seg_is_code), .seg_rw(seg_rw), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    typedef struct {
        logic [1:0] cause;
        string      tag;
        int         due;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Independent reference of the requirements.
    function automatic void model(input logic [31:0] off, input logic [2:0] len,
                                  input logic [1:0] kind, input logic [19:0] lim,
                                  input logic g, input logic ed, input logic code,
                                  input logic rw, output logic [1:0] cause,
                                  output string tag);
        longint eff, last, hi;
        bit wr, fe;
        wr = (kind == 2'd1);
        fe = (kind == 2'd2);
        eff  = g ? ((longint'(lim) << 12) | 64'hFFF) : longint'(lim);
        last = longint'(off) + longint'(len);
        if (wr && code)               begin cause = 2'd2; tag = "R7"; end
        else if (wr && !rw)           begin cause = 2'd2; tag = "R8"; end
        else if (fe && !code)         begin cause = 2'd3; tag = "R9"; end
        else if (!wr && !fe && code && !rw) begin cause = 2'd3; tag = "R9"; end
        else if (code || !ed) begin
            cause = (last > eff) ? 2'd1 : 2'd0; tag = "R3";
        end else begin
            hi = g ? 64'hFFFF_FFFF : 64'hF_FFFF;
            cause = (longint'(off) < eff || last > hi) ? 2'd1 : 2'd0; tag = "R5";
        end
    endfunction

    task automatic send(input string tag, input logic [31:0] off, input logic [2:0] len,
                        input logic [1:0] kind, input logic [19:0] lim,
                        input logic g, input logic ed, input logic code, input logic rw);
        exp_item_t it;
        string mtag;
        model(off, len, kind, lim, g, ed, code, rw, it.cause, mtag);
        it.tag = (tag == "") ? mtag : tag;
        it.due = cyc + 1;
        req_valid = 1'b1; req_offset = off; req_len_m1 = len; req_kind = kind;
        seg_limit = lim; seg_gran = g; seg_expand_down = ed;
        seg_is_code = code; seg_rw = rw;
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.tag, "cause", rsp_cause, it.cause);
                check("R2", "fault flag", rsp_fault, (it.cause != 2'd0));
                check("R1", "latency", cyc, it.due);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("WATCHDOG", "run finished", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_offset = '0; req_len_m1 = '0; req_kind = '0;
        seg_limit = '0; seg_gran = 0; seg_expand_down = 0; seg_is_code = 0; seg_rw = 0;
        repeat (3) @(negedge clk);
        check("R1", "reset valid", rsp_valid, 0);
        check("R1", "reset fault", rsp_fault, 0);
        check("R1", "reset cause", rsp_cause, 0);
        rst = 1'b0;
        @(negedge clk);

        // R3 grow-up bounds, limit inclusive
        send("R3", 32'h0FFF, 3'd0, 2'd0, 20'h00FFF, 0, 0, 0, 1);
        send("R3", 32'h1000, 3'd0, 2'd0, 20'h00FFF, 0, 0, 0, 1);
        // R6 multi-byte last byte
        send("R6", 32'h0FFE, 3'd1, 2'd0, 20'h00FFF, 0, 0, 0, 1);
        send("R6", 32'h0FFE, 3'd2, 2'd0, 20'h00FFF, 0, 0, 0, 1);
        // R4 page granularity
        send("R4", 32'h1FFF, 3'd0, 2'd0, 20'h00001, 1, 0, 0, 1);
        send("R4", 32'h2000, 3'd0, 2'd0, 20'h00001, 1, 0, 0, 1);
        send("R4", 32'hFFFF_FFFF, 3'd0, 2'd0, 20'hFFFFF, 1, 0, 0, 1);
        // R5 grow-down, byte granularity
        send("R5", 32'h0FFFF, 3'd0, 2'd0, 20'h10000, 0, 1, 0, 1);
        send("R5", 32'h10000, 3'd0, 2'd0, 20'h10000, 0, 1, 0, 1);
        send("R5", 32'hFFFFF, 3'd0, 2'd1, 20'h10000, 0, 1, 0, 1);
        send("R5", 32'hFFFFE, 3'd3, 2'd0, 20'h10000, 0, 1, 0, 1);
        // R5 grow-down, page granularity
        send("R5", 32'hFFFF_FFFC, 3'd3, 2'd0, 20'hFFFF0, 1, 1, 0, 1);
        send("R5", 32'hFFFF_0FFE, 3'd0, 2'd0, 20'hFFFF0, 1, 1, 0, 1);
        // R6 wrap past 32 bits
        send("R6", 32'hFFFF_FFFF, 3'd1, 2'd0, 20'hFFFF0, 1, 1, 0, 1);
        send("R6", 32'hFFFF_FFFA, 3'd7, 2'd0, 20'hFFFFF, 1, 0, 0, 1);
        // R7 / R8 write rights
        send("R7", 32'h10, 3'd0, 2'd1, 20'h00FFF, 0, 0, 1, 1);
        send("R8", 32'h10, 3'd0, 2'd1, 20'h00FFF, 0, 0, 0, 0);
        send("R8", 32'h10, 3'd3, 2'd1, 20'h00FFF, 0, 0, 0, 1);
        // R9 read/fetch rights
        send("R9", 32'h10, 3'd0, 2'd0, 20'h00FFF, 0, 0, 1, 0);
        send("R9", 32'h10, 3'd0, 2'd2, 20'h00FFF, 0, 0, 1, 0);
        send("R9", 32'h10, 3'd0, 2'd2, 20'h00FFF, 0, 0, 0, 1);
        // R10 rights win over bound
        send("R10", 32'h5000, 3'd0, 2'd1, 20'h00FFF, 0, 0, 1, 1);
        send("R10", 32'h5000, 3'd0, 2'd2, 20'h00FFF, 0, 0, 0, 1);
        // R11 expand-down ignored for code
        send("R11", 32'h50, 3'd0, 2'd2, 20'h00100, 0, 1, 1, 0);
        send("R11", 32'h101, 3'd0, 2'd2, 20'h00100, 0, 1, 1, 0);
        // R12 kind 3 acts as read
        send("R12", 32'h10, 3'd0, 2'd3, 20'h00FFF, 0, 0, 1, 0);
        send("R12", 32'h10, 3'd0, 2'd3, 20'h00FFF, 0, 0, 0, 0);

        // R1 idle cycle gives quiet outputs
        @(negedge clk);
        check("R1", "idle valid", rsp_valid, 0);
        check("R1", "idle fault", rsp_fault, 0);
        check("R1", "idle cause", rsp_cause, 0);

        // Random back-to-back traffic near the bounds
        for (int i = 0; i < 400; i++) begin
            logic [19:0] lim;
            logic [31:0] off;
            logic        g;
            g   = 1'($urandom);
            lim = 20'($urandom);
            off = g ? ({lim, 12'hFFF} + 32'($signed(5'($urandom))))
                    : ({12'h0, lim} + 32'($signed(5'($urandom))));
            if ((i % 4) == 0) off = 32'($urandom);
            send("", off, 3'($urandom), 2'($urandom), lim, g,
                 1'($urandom), 1'($urandom), 1'($urandom));
        end

        repeat (3) @(negedge clk);
        check("R1", "scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule